// File: doc/BRIEF.md
# Prescaled Programmable Baud Tick Generator

This block produces the single timing enable that paces both the transmitter and the receiver of a serial port. The enable is one reference-clock cycle wide and fires at sixteen times the wanted bit rate. The reference clock is first thinned by a selectable prescaler (divide by 1 or divide by 4). A 16-bit programmable divider then divides it further, so the tick rate is reference / (P × D), and the divisor for a given rate is D = (reference / P) / (16 × baud).

Software programs the divisor as two bytes through a small write port and picks the prescale through bit 7 of a mode register. While reset is held, an external select pin sets the prescale, and the mode register bit is loaded with the matching value. A divisor of zero halts the tick, which leaves the serial port without timing. Any register write restarts the prescaler and the divider from zero, so a new setting never produces a shortened first period.

Top module: `baud_tick_gen`

## Requirements
- R1: The divisor D is 16 bits wide: a write to address 0 sets bits 7:0 and a write to address 1 sets bits 15:8. With D nonzero and prescale P, `tick_o` is high once every P × D reference cycles, for every D from 1 to 65535.
- R2: `tick_o` is high for one cycle per period; with D = 1 and P = 1 it is high on every cycle.
- R3: A write to address 2 sets the prescale from data bit 7: 0 gives P = 1, 1 gives P = 4.
- R4: While `rst_n` is low, the select pin sets the prescale: `clk_sel_i` high gives P = 1, low gives P = 4. The mode bit is loaded with the inverse of the pin.
- R5: While D is zero, `tick_o` stays low.
- R6: Any write to address 0, 1 or 2 restarts counting. `tick_o` is low on the cycle after the write edge and first rises P × D + 1 edges after the write edge.
- R7: After reset, D is zero and `tick_o` is low.
- R8: A write to address 3 changes no setting and does not restart counting.
- R9: Bits 6:0 of a write to address 2 have no effect on the prescale.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_sel_i | input | 1 | Prescale select pin, sampled while reset is held (high = divide by 1) |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address: 0 divisor low byte, 1 divisor high byte, 2 mode, 3 unused |
| wr_data_i | input | 8 | Write data |
| tick_o | output | 1 | One-cycle enable at 16× the baud rate |

## Verification
The assertions assume that every input is synchronous to `clk` and that `clk_sel_i` is steady during each reset edge. They also assume that `wr_addr_i` and `wr_data_i` are valid whenever `wr_en_i` is high. The bench changes every input on the falling edge and holds `clk_sel_i` constant for the whole of each reset pulse, so the rising edge always sees settled values. Writes last exactly one cycle, and the bench never writes while reset is asserted.

// File: rtl/baud_gen_pkg.sv
package baud_gen_pkg;
    localparam int unsigned DIV_W     = 16;
    localparam int unsigned BYTE_W    = 8;
    localparam int unsigned ADDR_W    = 2;
    localparam int unsigned PRE_RATIO = 4;
    localparam int unsigned MODE_BIT  = 7;

    localparam int unsigned NUM_BYTES = DIV_W / BYTE_W;
    localparam int unsigned PRE_W     = $clog2(PRE_RATIO);
    localparam logic [ADDR_W-1:0] MODE_ADDR = ADDR_W'(NUM_BYTES);

    typedef struct packed {
        logic [DIV_W-1:0] divisor;
        logic             pre_sel;
        logic             reload;
    } regs_state_t;

    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } pre_state_t;

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             tick;
    } div_state_t;
endpackage

// File: rtl/baud_regs.sv
module baud_regs
    import baud_gen_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_sel_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [BYTE_W-1:0] wr_data_i,
    output logic [DIV_W-1:0]  divisor_o,
    output logic              pre_sel_o,
    output logic              reload_o
);
    regs_state_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.reload = 1'b0;
        if (wr_en_i) begin
            for (int i = 0; i < NUM_BYTES; i++) begin
                if (wr_addr_i == ADDR_W'(i)) begin
                    s_d.divisor[i*BYTE_W +: BYTE_W] = wr_data_i;
                    s_d.reload                      = 1'b1;
                end
            end
            if (wr_addr_i == MODE_ADDR) begin
                s_d.pre_sel = wr_data_i[MODE_BIT];
                s_d.reload  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.divisor <= '0;
            s_q.pre_sel <= ~clk_sel_i;
            s_q.reload  <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign divisor_o = s_q.divisor;
    assign pre_sel_o = s_q.pre_sel;
    assign reload_o  = s_q.reload;

    // R6: a write to a real register is followed by a restart pulse
    assert_write_reloads_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i != ADDR_W'(2**ADDR_W - 1)) |=> reload_o);

    // R8: the spare address leaves every setting untouched
    assert_spare_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i == ADDR_W'(2**ADDR_W - 1))
        |=> ($stable(divisor_o) && $stable(pre_sel_o) && !reload_o));
endmodule

// File: rtl/baud_prescaler.sv
module baud_prescaler
    import baud_gen_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pre_sel_i,
    input  logic restart_i,
    output logic en_o
);
    localparam logic [PRE_W-1:0] LAST = PRE_W'(PRE_RATIO - 1);

    pre_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (restart_i || !pre_sel_i) begin
            s_d.cnt = '0;
        end else if (s_q.cnt == LAST) begin
            s_d.cnt = '0;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.cnt <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign en_o = !pre_sel_i || (s_q.cnt == LAST);

    // R3: in divide-by-4 mode two consecutive enables never occur
    assert_pre_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_sel_i && en_o) |=> (!en_o || !pre_sel_i));
endmodule

// File: rtl/baud_divider.sv
module baud_divider
    import baud_gen_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] divisor_i,
    input  logic             en_i,
    input  logic             restart_i,
    output logic             tick_o
);
    div_state_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.tick = 1'b0;
        if (restart_i || divisor_i == '0) begin
            s_d.cnt = '0;
        end else if (en_i) begin
            if (s_q.cnt == divisor_i - 1'b1) begin
                s_d.cnt  = '0;
                s_d.tick = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.cnt  <= '0;
            s_q.tick <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign tick_o = s_q.tick;

    // R5: a zero divisor gives no tick
    assert_zero_halts_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (divisor_i == '0) |=> !tick_o);

    // R6: the cycle after a restart is quiet and the count is cleared
    assert_restart_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (!tick_o && s_q.cnt == '0));

    // R1: the count stays below the programmed divisor
    assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (divisor_i != '0 && !restart_i) |-> (s_q.cnt < divisor_i));
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
    import baud_gen_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_sel_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [BYTE_W-1:0] wr_data_i,
    output logic              tick_o
);
    logic [DIV_W-1:0] divisor;
    logic             pre_sel;
    logic             reload;
    logic             pre_en;

    baud_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .clk_sel_i (clk_sel_i),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .divisor_o (divisor),
        .pre_sel_o (pre_sel),
        .reload_o  (reload)
    );

    baud_prescaler u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .pre_sel_i (pre_sel),
        .restart_i (reload),
        .en_o      (pre_en)
    );

    baud_divider u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .divisor_i (divisor),
        .en_i      (pre_en),
        .restart_i (reload),
        .tick_o    (tick_o)
    );

    // R2: with divisor 1 at full rate the tick stays high
    assert_full_rate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (divisor == DIV_W'(1) && !pre_sel && !reload && $past(tick_o)) |=> tick_o);
endmodule

// File: tb/tb_baud_tick_gen.sv
module tb_baud_tick_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clk_sel = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       tick;

    always #2.5 clk = ~clk;

    baud_tick_gen dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .clk_sel_i (clk_sel),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .tick_o    (tick)
    );

    int    vectors = 0;
    int    errors  = 0;
    int    cyc     = 0;
    string cur_req = "R7";

    // behavioural reference
    int  m_div   = 0;
    bit  m_div4  = 0;
    int  m_phase = 0;
    bit  m_exp   = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_div   = 0;
            m_div4  = !clk_sel;
            m_phase = 0;
            m_exp   = 0;
        end else begin
            m_phase = m_phase + 1;
            m_exp = (m_div != 0) && (m_phase > 0) &&
                    ((m_phase % ((m_div4 ? 4 : 1) * m_div)) == 0);
            if (wr_en && wr_addr != 2'd3) begin
                case (wr_addr)
                    2'd0: m_div = (m_div & 32'hFF00) | int'(wr_data);
                    2'd1: m_div = (m_div & 32'h00FF) | (int'(wr_data) << 8);
                    default: m_div4 = wr_data[7];
                endcase
                m_phase = -1;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        cyc++;
        check(tick === m_exp, cur_req, int'(tick), int'(m_exp));
        if (cyc > 190000) begin
            errors++;
            $display("FAIL watchdog actual %0d expected %0d", cyc, 190000);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    task automatic do_reset(input bit sel);
        clk_sel = sel;
        rst_n   = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_tick(output int at);
        at = -1;
        for (int i = 0; i < 70000; i++) begin
            @(negedge clk);
            if (tick) begin
                at = cyc;
                break;
            end
        end
    endtask

    task automatic check_period(input int exp, input string req);
        int t1, t2;
        wait_tick(t1);
        wait_tick(t2);
        check((t1 >= 0) && (t2 - t1 == exp), req, t2 - t1, exp);
    endtask

    task automatic count_ticks(input int n, output int cnt);
        cnt = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (tick) cnt++;
        end
    endtask

    initial begin
        int n, lat, c0;
        @(negedge clk);
        do_reset(1'b1);

        cur_req = "R7";
        check(tick == 1'b0, "R7 tick after reset", int'(tick), 0);
        cur_req = "R5";
        count_ticks(50, n);
        check(n == 0, "R5 zero divisor after reset", n, 0);

        cur_req = "R2";
        wr(2'd0, 8'd1);
        @(negedge clk);
        count_ticks(20, n);
        check(n == 20, "R2 divisor 1 every cycle", n, 20);

        cur_req = "R1";
        wr(2'd0, 8'd5);
        check_period(5, "R1 divisor 5");
        wr(2'd1, 8'h01);
        check_period(261, "R1 high byte position");

        cur_req = "R3";
        wr(2'd2, 8'h80);
        check_period(1044, "R3 mode bit 7 set gives divide by 4");
        cur_req = "R9";
        wr(2'd2, 8'h7F);
        check_period(261, "R9 low mode bits ignored");

        cur_req = "R8";
        wr(2'd3, 8'hFF);
        check_period(261, "R8 spare address ignored");

        cur_req = "R6";
        wr(2'd1, 8'h00);
        wr(2'd0, 8'd3);
        c0 = cyc;
        wait_tick(lat);
        check(lat - c0 == 4, "R6 first tick latency", lat - c0, 4);
        wr(2'd2, 8'h80);
        c0 = cyc;
        wait_tick(lat);
        check(lat - c0 == 13, "R6 restart on mode write", lat - c0, 13);

        cur_req = "R5";
        wr(2'd0, 8'd0);
        count_ticks(200, n);
        check(n == 0, "R5 zero divisor halts", n, 0);

        cur_req = "R4";
        do_reset(1'b0);
        check(tick == 1'b0, "R7 tick after second reset", int'(tick), 0);
        wr(2'd0, 8'd2);
        check_period(8, "R4 pin low gives divide by 4");
        cur_req = "R3";
        wr(2'd2, 8'h00);
        check_period(2, "R3 mode bit clear overrides pin");

        cur_req = "R1";
        do_reset(1'b1);
        wr(2'd0, 8'd2);
        check_period(2, "R4 pin high gives divide by 1");
        wr(2'd0, 8'hFF);
        wr(2'd1, 8'hFF);
        check_period(65535, "R1 maximum divisor");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule